// File: doc/BRIEF.md
# System-Clocked SPI Byte Slave

This block is the target side of a mode 0 SPI link (clock idles low; data sampled on the rising clock edge and shifted on the falling edge). It does not use the serial clock as a clock. The serial clock, chip select and data input pass through two-flop synchronizers into the block's own system clock domain. Edge detectors then turn them into single-cycle events that drive an 8-bit receive shift register and an 8-bit transmit shift register. Bits travel most significant first in both directions.

Received bytes leave the block on a parallel bus with a one-cycle valid strobe. The byte to be returned to the master is handed in through a valid/ready handshake into a one-byte holding stage. That stage is moved into the transmit shift register when the chip select opens and at every byte boundary inside the chip-select window. When nothing has been handed in, zeros go out. The system clock must run at least four times faster than the serial clock.

Top module: `spis_slave`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a clock edge) leaves `tx_ready` = 1, `rx_valid` = 0 and `spi_miso` = 0.
- R2: While `spi_csn` is low, `spi_mosi` is sampled on each rising edge of `spi_sclk`. The first sampled bit ends up in bit 7 of `rx_data`, so after eight rising edges `rx_data` holds the byte sent MSB first.
- R3: `rx_valid` is high for exactly one system clock per completed byte, and `rx_data` changes only in a cycle where `rx_valid` is high.
- R4: A transmit byte is taken in a cycle where `tx_valid` and `tx_ready` are both 1. `tx_ready` is then 0 until that byte is moved into the transmit shift register.
- R5: When `spi_csn` goes low, the held byte is loaded, and its bit 7 appears on `spi_miso` before the first rising `spi_sclk` edge. Each falling `spi_sclk` edge advances `spi_miso` by one bit, MSB first.
- R6: A byte handed in during a transfer is sent as the next byte in the same chip-select window, and reception continues without a gap.
- R7: If no byte is held at a byte boundary, or when the chip select opens, the next byte sent on `spi_miso` is all zeros.
- R8: `spi_miso` is 0 while `spi_csn` is high, including when `spi_sclk` toggles.
- R9: When `spi_csn` rises in the middle of a byte, the partial byte is dropped without an `rx_valid`, and the next window starts counting from bit 7 again.
- R10: Rising `spi_sclk` edges while `spi_csn` is high are ignored. They produce no `rx_valid` and do not advance the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Synchronous reset, active low |
| spi_sclk | input | 1 | Serial clock from the master (asynchronous) |
| spi_csn | input | 1 | Chip select, active low (asynchronous) |
| spi_mosi | input | 1 | Serial data from master (asynchronous) |
| spi_miso | output | 1 | Serial data to master |
| tx_data | input | W | Byte to send back to the master |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Holding stage empty; an offered byte is taken |
| rx_data | output | W | Last complete received byte |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_data` |

## Verification
The bench goes after the byte boundary. A design that reloads the transmit register one edge late would send the old byte's shifted-out zeros or lose the MSB of the queued byte, and the per-bit MISO checks catch both. A chip-select window closed after three bits must leave no strobe, and the next full byte must decode intact: a counter that survives the window would strobe early with a misaligned byte. Clock pulses with the chip select high must not move the counter or MISO, and a design that gates only the strobe would corrupt the following byte. Back-to-back bytes with a byte queued mid-window, followed by one with nothing queued, show whether the holding stage is consumed at the right time and whether zeros are sent when it is empty.

// File: rtl/spis_pkg.sv
// Shared types for the system-clocked SPI slave.
// Assumes: a single clock domain after synchronization.
package spis_pkg;

    // Single-cycle events derived from the synchronized serial inputs.
    typedef struct packed {
        logic sclk_rise;   // serial clock went 0 -> 1
        logic sclk_fall;   // serial clock went 1 -> 0
        logic cs_start;    // chip select just became active
        logic cs_active;   // chip select currently active
    } spis_evt_t;

endpackage

// File: rtl/spis_sync.sv
// Multi-bit, multi-stage synchronizer for asynchronous inputs.
// Each bit is synchronized on its own; no coherence between bits is
// implied. Assumes inputs are stable for several system clocks.
module spis_sync #(
    parameter int          N       = 1,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    logic [N-1:0] stg [STAGES];

    // Shift the inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg[i] <= RST_VAL;
            end
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spis_edge.sv
// Edge detector for the synchronized serial clock and chip select.
// Produces one-cycle events. Assumes the serial clock half period is
// at least two system clocks, so no edge is missed.
module spis_edge
    import spis_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sclk_s,
    input  logic      csn_s,
    output spis_evt_t evt
);

    logic sclk_d;
    logic csn_d;

    // Remember last cycle's levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            csn_d  <= csn_s;
        end
    end

    // Decode edges into the event bundle.
    always_comb begin
        evt.sclk_rise = sclk_s & ~sclk_d;
        evt.sclk_fall = ~sclk_s & sclk_d;
        evt.cs_start  = ~csn_s & csn_d;
        evt.cs_active = ~csn_s;
    end

endmodule

// File: rtl/spis_rx.sv
// Receive path: MSB-first shift register with a bit counter.
// The counter is held at zero whenever the chip select is inactive, so
// a window that closes mid-byte drops the partial byte. Assumes
// sample_en is qualified with an active chip select.
module spis_rx #(
    parameter int W     = 8,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic             cs_active,
    input  logic             mosi_s,
    output logic [W-1:0]     rx_data,
    output logic             rx_valid,
    output logic [CNT_W-1:0] bit_cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [W-1:0] rx_sh;
    logic [W-1:0] next_sh;
    logic         last_bit;

    assign next_sh  = {rx_sh[W-2:0], mosi_s};
    assign last_bit = sample_en && (bit_cnt == LAST);

    // Count sampled bits within a chip-select window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (!cs_active) begin
            bit_cnt <= '0;
        end else if (sample_en) begin
            bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
        end
    end

    // Shift incoming data in on each qualified rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh <= '0;
        end else if (sample_en) begin
            rx_sh <= next_sh;
        end
    end

    // Publish a completed byte with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= last_bit;
            if (last_bit) begin
                rx_data <= next_sh;
            end
        end
    end

endmodule

// File: rtl/spis_tx.sv
// Transmit path: one-byte holding stage with valid/ready input and an
// MSB-first shift register. The stage moves into the shift register
// when the chip select opens and on the falling edge that follows a
// completed byte; if empty, zeros are loaded. Output is gated low
// while the chip select is inactive.
module spis_tx #(
    parameter int W     = 8,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_start,
    input  logic             cs_active,
    input  logic             shift_en,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic [W-1:0]     tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic             miso
);

    logic [W-1:0] hold;
    logic         full;
    logic [W-1:0] tx_sh;
    logic         out_en;
    logic         accept;
    logic         boundary;
    logic         take;
    logic [W-1:0] fresh;

    assign accept   = tx_valid & ~full;
    assign boundary = shift_en && (bit_cnt == '0);
    assign take     = cs_start | boundary;
    assign fresh    = full ? hold : '0;

    // Holding stage: fill on handshake, empty when moved out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
            full <= 1'b0;
        end else if (accept) begin
            hold <= tx_data;
            full <= 1'b1;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // Shift register: load at window start or byte boundary, else shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (take) begin
            tx_sh <= fresh;
        end else if (shift_en) begin
            tx_sh <= {tx_sh[W-2:0], 1'b0};
        end
    end

    // Output enable follows the chip select in step with the load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_en <= 1'b0;
        end else begin
            out_en <= cs_active;
        end
    end

    assign tx_ready = ~full;
    assign miso     = out_en & tx_sh[W-1];

endmodule

// File: rtl/spis_slave.sv
// Mode 0 SPI slave run entirely from the system clock.
// Serial inputs are synchronized, edge-detected and used as enables
// for the receive and transmit shift paths. Assumes the system clock
// is at least four times the serial clock rate.
module spis_slave #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         spi_sclk,
    input  logic         spi_csn,
    input  logic         spi_mosi,
    output logic         spi_miso,
    input  logic [W-1:0] tx_data,
    input  logic         tx_valid,
    output logic         tx_ready,
    output logic [W-1:0] rx_data,
    output logic         rx_valid
);

    import spis_pkg::*;

    localparam int CNT_W = (W > 2) ? $clog2(W) : 1;

    logic [2:0]       sync_q;
    logic             sclk_s;
    logic             csn_s;
    logic             mosi_s;
    spis_evt_t        evt;
    logic [CNT_W-1:0] bit_cnt;
    logic             sample_en;
    logic             shift_en;

    spis_sync #(
        .N       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_mosi, spi_csn, spi_sclk}),
        .q     (sync_q)
    );

    assign sclk_s = sync_q[0];
    assign csn_s  = sync_q[1];
    assign mosi_s = sync_q[2];

    spis_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (sclk_s),
        .csn_s  (csn_s),
        .evt    (evt)
    );

    assign sample_en = evt.sclk_rise & evt.cs_active;
    assign shift_en  = evt.sclk_fall & evt.cs_active;

    spis_rx #(
        .W     (W),
        .CNT_W (CNT_W)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .cs_active (evt.cs_active),
        .mosi_s    (mosi_s),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .bit_cnt   (bit_cnt)
    );

    spis_tx #(
        .W     (W),
        .CNT_W (CNT_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_start  (evt.cs_start),
        .cs_active (evt.cs_active),
        .shift_en  (shift_en),
        .bit_cnt   (bit_cnt),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .miso      (spi_miso)
    );

endmodule

// File: rtl/spis_slave_chk.sv
// Protocol checker for spis_slave, attached by bind.
// Observes ports plus the synchronized chip select and the bit count.
module spis_slave_chk #(
    parameter int W     = 8,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             csn_s,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             miso,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [W-1:0]     rx_data,
    input logic             rx_valid
);

    // R3: strobe lasts one cycle.
    p_vld_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R3: received data only changes together with the strobe.
    p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> rx_valid);

    // R4: an accepted byte closes the handshake next cycle.
    p_ready_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R8: output low once chip select has been inactive two cycles.
    p_miso_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_s && $past(csn_s)) |-> !miso);

    // R9: bit count cleared after an inactive chip select.
    p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> (bit_cnt == '0));

    // R10: strobe only from edges inside an active window.
    p_vld_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !$past(csn_s));

endmodule

bind spis_slave spis_slave_chk #(
    .W     (W),
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .csn_s    (csn_s),
    .bit_cnt  (bit_cnt),
    .miso     (spi_miso),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
);

// File: tb/spis_slave_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the serial driver queues expected receive bytes,
// a monitor pops them on each strobe. MISO is checked bit by bit.
module spis_slave_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0;
    logic       spi_csn = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_valid;

    int checks = 0;
    int errors = 0;
    int vld_cnt = 0;
    logic [7:0] exp_q[$];
    logic       vld_prev = 1'b0;
    logic [7:0] data_prev = '0;
    bit         mon_on = 1'b0;

    always #2.5 clk = ~clk;

    spis_slave u_spis_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_sclk (spi_sclk),
        .spi_csn  (spi_csn),
        .spi_mosi (spi_mosi),
        .spi_miso (spi_miso),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Monitor: pop expected bytes on each strobe, check pulse and hold.
    always @(negedge clk) begin
        if (mon_on) begin
            if (rx_valid) begin
                vld_cnt++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected strobe", {24'h0, rx_data}, 32'h0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rx_data === e, "R2 received byte", {24'h0, rx_data}, {24'h0, e});
                end
                if (vld_prev) chk(1'b0, "R3 strobe longer than one cycle", 32'h1, 32'h0);
            end else if (rx_data !== data_prev) begin
                chk(1'b0, "R3 data changed without strobe", {24'h0, rx_data}, {24'h0, data_prev});
            end
            vld_prev  = rx_valid;
            data_prev = rx_data;
        end
    end

    // Driver: shift nbits MSB first, check MISO before each rising edge.
    task automatic xfer(input logic [7:0] mo, input logic [7:0] exp_mi, input string tag, input int nbits);
        if (nbits == 8) exp_q.push_back(mo);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            spi_mosi = mo[7-i];
            repeat (4) @(negedge clk);
            chk(spi_miso === exp_mi[7-i], tag, {31'h0, spi_miso}, {31'h0, exp_mi[7-i]});
            spi_sclk = 1'b1;
            repeat (4) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic push_tx(input logic [7:0] b);
        @(negedge clk);
        tx_data  = b;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        chk(tx_ready === 1'b0, "R4 ready low after accept", {31'h0, tx_ready}, 32'h0);
    endtask

    task automatic cs_open();
        @(negedge clk);
        spi_csn = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic cs_close();
        repeat (4) @(negedge clk);
        spi_csn = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'h0, 32'h0);
        finish_run();
    end

    initial begin
        int v0;
        repeat (5) @(negedge clk);
        // R1: reset state.
        chk(tx_ready === 1'b1, "R1 ready after reset", {31'h0, tx_ready}, 32'h1);
        chk(rx_valid === 1'b0, "R1 no strobe in reset", {31'h0, rx_valid}, 32'h0);
        chk(spi_miso === 1'b0, "R1 miso low in reset", {31'h0, spi_miso}, 32'h0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (3) @(negedge clk);

        // R4/R5/R6/R7: preload, three back-to-back bytes.
        push_tx(8'hA5);
        cs_open();
        chk(spi_miso === 1'b1, "R5 MSB before first edge", {31'h0, spi_miso}, 32'h1);
        chk(tx_ready === 1'b1, "R4 ready after load", {31'h0, tx_ready}, 32'h1);
        push_tx(8'h5A);
        xfer(8'h3C, 8'hA5, "R5 miso bit", 8);
        xfer(8'hC7, 8'h5A, "R6 queued byte bit", 8);
        chk(tx_ready === 1'b1, "R6 ready after boundary", {31'h0, tx_ready}, 32'h1);
        xfer(8'h01, 8'h00, "R7 empty stage zeros", 8);
        cs_close();
        chk(spi_miso === 1'b0, "R8 miso low after close", {31'h0, spi_miso}, 32'h0);
        chk(vld_cnt == 3, "R2 three bytes received", vld_cnt, 32'd3);

        // R9: partial byte dropped, next window aligned.
        v0 = vld_cnt;
        cs_open();
        xfer(8'hFF, 8'h00, "R7 no load zeros", 3);
        cs_close();
        chk(vld_cnt == v0, "R9 partial byte no strobe", vld_cnt, v0);
        push_tx(8'h96);
        cs_open();
        xfer(8'h81, 8'h96, "R9 fresh window miso", 8);
        cs_close();
        chk(vld_cnt == v0 + 1, "R9 full byte after partial", vld_cnt, v0 + 1);

        // R10/R8: clock pulses with chip select high.
        v0 = vld_cnt;
        spi_mosi = 1'b1;
        for (int i = 0; i < 8; i++) begin
            repeat (4) @(negedge clk);
            spi_sclk = 1'b1;
            repeat (4) @(negedge clk);
            chk(spi_miso === 1'b0, "R8 miso idle while clocked", {31'h0, spi_miso}, 32'h0);
            spi_sclk = 1'b0;
        end
        repeat (6) @(negedge clk);
        chk(vld_cnt == v0, "R10 no strobe outside window", vld_cnt, v0);
        cs_open();
        xfer(8'hC3, 8'h00, "R10 miso zeros", 8);
        cs_close();
        chk(vld_cnt == v0 + 1, "R10 count not advanced", vld_cnt, v0 + 1);
        chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 32'h0);

        finish_run();
    end

endmodule